// File: doc/BRIEF.md
# Selectable Reference Rate Divider

This block divides a reference clock down to the rate at which a phase comparator works. Two select pins choose one of four ratios (35, 36, 38 or 32). With the four matching reference frequencies (17.92, 18.432, 19.456 and 16.384 MHz), every ratio produces the same 512 kHz comparison rate.

The block has three outputs. The first is a one-cycle compare strobe at the end of each divided period. The second is a divided clock that is HIGH for the first half of each period. The third is a test tap that copies the divided clock only while both control pins are HIGH and otherwise stays LOW. A ratio change is taken in only at a period boundary, so the output never has a shortened period.

An optional synchronizer can be placed in front of the select pins. With its default depth of zero the pins feed the ratio decoder directly.

Top module: `refdiv_top`

## Requirements
- R1: The strobe period in reference cycles follows the select pins {s1_i,s2_i}: 0,0 gives 35; 1,0 gives 36; 0,1 gives 38; 1,1 gives 32.
- R2: cmp_stb_o is HIGH for exactly one cycle per divided period and LOW in the cycle after each pulse.
- R3: div_o is LOW in the strobe cycle. It goes HIGH in the cycle after the strobe and stays HIGH for floor(N/2) cycles of each N-cycle period.
- R4: While c1_i and c2_i are both HIGH, tap_o equals div_o in the following cycle.
- R5: For any other combination of c1_i and c2_i, tap_o is LOW in the following cycle.
- R6: A change of the select pins takes effect only at the end of the period in progress. That period completes with the old ratio and the next one uses the new ratio.
- R7: While rst_ni is LOW, all three outputs are LOW from the first clock edge on, and no strobe occurs. After release, the first strobe appears N cycles later, where N is the ratio selected during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous reset, active LOW |
| s1_i | input | 1 | Ratio select bit 1 |
| s2_i | input | 1 | Ratio select bit 2 |
| c1_i | input | 1 | Control bit 1 (test mode when both are HIGH) |
| c2_i | input | 1 | Control bit 2 |
| cmp_stb_o | output | 1 | One-cycle compare strobe at the end of each period |
| div_o | output | 1 | Divided clock, HIGH for floor(N/2) cycles |
| tap_o | output | 1 | Test copy of div_o, LOW outside test mode |

## Verification
The hardest case to reach from the ports is a select change that arrives in the middle of a period. Only the length of the period that is already running shows whether the block resized it. The stimulus first locks onto a strobe and then flips the select pins at a chosen cycle offset, once right after the boundary and once deep inside the period. It then measures two whole periods and expects the old ratio followed by the new one. A reset asserted in the middle of a count is also checked, to show that the outputs go LOW and stay silent.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

   typedef logic [1:0] sel_t;   // {s2, s1}

   // Maps the select code to the configured ratio.
   function automatic int unsigned pick_ratio(input sel_t code,
                                              input int unsigned r_ll,
                                              input int unsigned r_hl,
                                              input int unsigned r_lh,
                                              input int unsigned r_hh);
      unique case (code)
         2'b00:   return r_ll;
         2'b01:   return r_hl;
         2'b10:   return r_lh;
         default: return r_hh;
      endcase
   endfunction

endpackage

// File: rtl/refdiv_ratio_sel.sv
module refdiv_ratio_sel
   import refdiv_pkg::*;
#(
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned R_LL     = 35,
   parameter int unsigned R_HL     = 36,
   parameter int unsigned R_LH     = 38,
   parameter int unsigned R_HH     = 32,
   parameter int unsigned SEL_SYNC = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             s1_i,
   input  logic             s2_i,
   output logic [CNT_W-1:0] ratio_o
);

   sel_t raw_code;
   sel_t eff_code;

   assign raw_code = {s2_i, s1_i};

   generate
      if (SEL_SYNC == 0) begin : g_direct
         assign eff_code = raw_code;
      end else begin : g_sync
         sel_t stage_q [SEL_SYNC];
         // In reset every stage follows the pins, so the ratio loaded
         // at reset release is the one present on the pins.
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               for (int i = 0; i < SEL_SYNC; i++) stage_q[i] <= raw_code;
            end else begin
               stage_q[0] <= raw_code;
               for (int i = 1; i < SEL_SYNC; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign eff_code = stage_q[SEL_SYNC-1];
      end
   endgenerate

   assign ratio_o = CNT_W'(pick_ratio(eff_code, R_LL, R_HL, R_LH, R_HH));

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] next_ratio_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cur_ratio_o,
   output logic             term_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] ratio_q;

   assign term_o = (cnt_q == ratio_q - CNT_W'(1));

   // The ratio is taken in only at reset or at terminal count, so a
   // period that has started always runs to its full length.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         ratio_q <= next_ratio_i;
      end else if (term_o) begin
         cnt_q   <= '0;
         ratio_q <= next_ratio_i;
      end else begin
         cnt_q   <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o       = cnt_q;
   assign cur_ratio_o = ratio_q;

endmodule

// File: rtl/refdiv_outs.sv
module refdiv_outs #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cur_ratio_i,
   input  logic             term_i,
   input  logic             tap_en_i,
   output logic             stb_o,
   output logic             div_o,
   output logic             tap_o
);

   logic [CNT_W-1:0] half;
   logic             first_half;
   logic             stb_q, div_q, tap_q;

   assign half       = cur_ratio_i >> 1;
   assign first_half = (cnt_i < half);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         stb_q <= 1'b0;
         div_q <= 1'b0;
         tap_q <= 1'b0;
      end else begin
         stb_q <= term_i;
         div_q <= first_half;
         tap_q <= tap_en_i & first_half;
      end
   end

   assign stb_o = stb_q;
   assign div_o = div_q;
   assign tap_o = tap_q;

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned R_LL     = 35,
   parameter int unsigned R_HL     = 36,
   parameter int unsigned R_LH     = 38,
   parameter int unsigned R_HH     = 32,
   parameter int unsigned SEL_SYNC = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic s1_i,
   input  logic s2_i,
   input  logic c1_i,
   input  logic c2_i,
   output logic cmp_stb_o,
   output logic div_o,
   output logic tap_o
);

   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_w
         $error("refdiv_top: CNT_W out of range");
      end
      if (R_LL < 2 || R_LL > CNT_MAX || R_HL < 2 || R_HL > CNT_MAX ||
          R_LH < 2 || R_LH > CNT_MAX || R_HH < 2 || R_HH > CNT_MAX) begin : g_bad_r
         $error("refdiv_top: a ratio does not fit CNT_W or is below 2");
      end
      if (SEL_SYNC > 4) begin : g_bad_s
         $error("refdiv_top: SEL_SYNC too deep");
      end
   endgenerate

   logic [CNT_W-1:0] next_ratio;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cur_ratio;
   logic             term;
   logic             tap_en;

   assign tap_en = c1_i & c2_i;

   refdiv_ratio_sel #(
      .CNT_W(CNT_W), .R_LL(R_LL), .R_HL(R_HL), .R_LH(R_LH), .R_HH(R_HH),
      .SEL_SYNC(SEL_SYNC)
   ) u_sel (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .s1_i    (s1_i),
      .s2_i    (s2_i),
      .ratio_o (next_ratio)
   );

   refdiv_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .next_ratio_i (next_ratio),
      .cnt_o        (cnt),
      .cur_ratio_o  (cur_ratio),
      .term_o       (term)
   );

   refdiv_outs #(.CNT_W(CNT_W)) u_out (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cnt_i       (cnt),
      .cur_ratio_i (cur_ratio),
      .term_i      (term),
      .tap_en_i    (tap_en),
      .stb_o       (cmp_stb_o),
      .div_o       (div_o),
      .tap_o       (tap_o)
   );

endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
   parameter int unsigned CNT_W = 6,
   parameter int unsigned R_LL  = 35,
   parameter int unsigned R_HL  = 36,
   parameter int unsigned R_LH  = 38,
   parameter int unsigned R_HH  = 32
) (
   input logic clk_i,
   input logic rst_ni,
   input logic c1_i,
   input logic c2_i,
   input logic cmp_stb_o,
   input logic div_o,
   input logic tap_o
);

   localparam int unsigned GW = CNT_W + 1;
   localparam logic [GW-1:0] GMAX = '1;

   logic [GW-1:0] gap_q;
   logic [GW-1:0] hi_q;
   logic          seen_q;

   // gap_q: cycles since the last strobe. hi_q: div_o HIGH cycles seen since then.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         gap_q  <= '0;
         hi_q   <= '0;
         seen_q <= 1'b0;
      end else if (cmp_stb_o) begin
         gap_q  <= GW'(1);
         hi_q   <= '0;
         seen_q <= 1'b1;
      end else begin
         if (gap_q != GMAX) gap_q <= gap_q + GW'(1);
         if (hi_q  != GMAX) hi_q  <= hi_q + GW'(div_o);
      end
   end

   AST_PERIOD_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_stb_o && seen_q) |-> (gap_q == GW'(R_LL) || gap_q == GW'(R_HL) ||
                                 gap_q == GW'(R_LH) || gap_q == GW'(R_HH))); // R1
   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_stb_o |=> !cmp_stb_o); // R2
   AST_DIV_LOW_AT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_stb_o |-> !div_o); // R3
   AST_DIV_RISES_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_stb_o |=> div_o); // R3
   AST_HIGH_IS_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_stb_o && seen_q) |-> (hi_q == (gap_q >> 1))); // R3
   AST_TAP_MIRRORS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c1_i && c2_i) |=> (tap_o == div_o)); // R4
   AST_TAP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(c1_i && c2_i) |=> !tap_o); // R5
   AST_RESET_QUIET: assert property (@(posedge clk_i)
      !rst_ni |=> (!cmp_stb_o && !div_o && !tap_o)); // R7

endmodule

bind refdiv_top refdiv_chk #(
   .CNT_W(CNT_W), .R_LL(R_LL), .R_HL(R_HL), .R_LH(R_LH), .R_HH(R_HH)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .c1_i      (c1_i),
   .c2_i      (c2_i),
   .cmp_stb_o (cmp_stb_o),
   .div_o     (div_o),
   .tap_o     (tap_o)
);

// File: tb/sim_refdiv_top.sv
module sim_refdiv_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s1 = 1'b1, s2 = 1'b1, c1 = 1'b1, c2 = 1'b1;
   logic stb, dv, tap;

   int nchk = 0;
   int nerr = 0;

   always #10 clk = ~clk;   // 50 MHz

   refdiv_top u0 (
      .clk_i(clk), .rst_ni(rst_n), .s1_i(s1), .s2_i(s2), .c1_i(c1), .c2_i(c2),
      .cmp_stb_o(stb), .div_o(dv), .tap_o(tap)
   );

   // Entry: {s1, s2, c1, c2, expected ratio[5:0]}
   localparam logic [9:0] VEC [8] = '{
      {1'b0, 1'b0, 1'b1, 1'b1, 6'd35},
      {1'b1, 1'b0, 1'b0, 1'b0, 6'd36},
      {1'b0, 1'b1, 1'b1, 1'b0, 6'd38},
      {1'b1, 1'b1, 1'b0, 1'b1, 6'd32},
      {1'b1, 1'b1, 1'b1, 1'b1, 6'd32},
      {1'b0, 1'b1, 1'b1, 1'b1, 6'd38},
      {1'b1, 1'b0, 1'b1, 1'b1, 6'd36},
      {1'b0, 1'b0, 1'b0, 1'b0, 6'd35}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   task automatic wait_strobe();
      for (int n = 0; n < 200; n++) begin
         @(negedge clk);
         if (stb) return;
      end
      check(1'b0, "R2 strobe missing", 0, 1);
   endtask

   // Called just after a strobe sample. Counts one period up to and including
   // the next strobe. Optionally changes the select pins at cycle chg_at.
   task automatic measure(input int chg_at, input logic ns1, input logic ns2,
                          output int per, output int hi, output int tap_bad,
                          output int tap_hi, output bit after_ok);
      per = 0; hi = 0; tap_bad = 0; tap_hi = 0; after_ok = 1'b1;
      for (int n = 1; n < 200; n++) begin
         @(negedge clk);
         if (n == chg_at) begin s1 = ns1; s2 = ns2; end
         if (n == 1 && (stb || !dv)) after_ok = 1'b0;
         hi     += int'(dv);
         tap_hi += int'(tap);
         if (tap !== (dv & c1 & c2)) tap_bad++;
         if (stb) begin per = n; return; end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int per, hi, tb, th, n;
      bit aok;

      // R7: reset state
      repeat (4) @(negedge clk);
      check(stb == 1'b0, "R7 strobe in reset", int'(stb), 0);
      check(dv  == 1'b0, "R7 div in reset",    int'(dv),  0);
      check(tap == 1'b0, "R7 tap in reset",    int'(tap), 0);
      rst_n = 1'b1;
      n = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         n++;
         if (stb) break;
      end
      check(n == 32, "R7 first strobe delay", n, 32);

      // Table walk: R1 R2 R3 R4 R5
      foreach (VEC[i]) begin
         {s1, s2, c1, c2} = VEC[i][9:6];
         wait_strobe();   // period boundary where the new ratio is taken in
         measure(0, 1'b0, 1'b0, per, hi, tb, th, aok);
         check(per == int'(VEC[i][5:0]), "R1 period", per, int'(VEC[i][5:0]));
         check(aok, "R2/R3 strobe low and div high after pulse", int'(aok), 1);
         check(hi == int'(VEC[i][5:0]) / 2, "R3 high cycles", hi, int'(VEC[i][5:0]) / 2);
         if (c1 && c2) check(tb == 0 && th == hi, "R4 tap mirror", th, hi);
         else          check(tb == 0 && th == 0,  "R5 tap low",    th, 0);
      end

      // R6: a select change applies at the period boundary only
      s1 = 1'b0; s2 = 1'b0; c1 = 1'b0; c2 = 1'b0;
      wait_strobe();
      wait_strobe();
      measure(1, 1'b0, 1'b1, per, hi, tb, th, aok);
      check(per == 35, "R6 period after early change", per, 35);
      measure(0, 1'b0, 1'b0, per, hi, tb, th, aok);
      check(per == 38, "R6 new ratio next period", per, 38);
      measure(20, 1'b1, 1'b0, per, hi, tb, th, aok);
      check(per == 38, "R6 period after mid change", per, 38);
      measure(0, 1'b0, 1'b0, per, hi, tb, th, aok);
      check(per == 36, "R6 new ratio after mid change", per, 36);

      // R7: reset in the middle of a count
      c1 = 1'b1; c2 = 1'b1;
      repeat (7) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(!stb && !dv && !tap, "R7 outputs low after mid reset",
            int'({stb, dv, tap}), 0);
      n = 0;
      for (int k = 0; k < 50; k++) begin
         @(negedge clk);
         n += int'(stb | dv | tap);
      end
      check(n == 0, "R7 silent while in reset", n, 0);
      s1 = 1'b0; s2 = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      n = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         n++;
         if (stb) break;
      end
      check(n == 38, "R7 first strobe uses ratio from reset", n, 38);

      finish_run();
   end

endmodule